// File: doc/BRIEF.md
# Programmable System Watchdog with Two Timebases

This block is a system watchdog. Software loads an 8-bit timeout, counted in coarse units, into a preset register. It then writes a start command to a control register. From that point the block counts down one step per unit. A unit is either one input tick, nominally 2 seconds, or `LONG_DIV` input ticks, nominally 60 seconds. A bit in the control register selects which. Software must repeat the start command before the count runs out, and each repeat reloads the countdown. A separate stop command halts the watchdog.

When the count runs out, the block raises a one-cycle system reset request and latches a sticky "watchdog fired" flag. The flag drives an alarm output and software can clear it. If the power-off option bit is set and the thermal input is high at the moment of expiry, a power-off request pulses together with the reset request. After expiry the watchdog stays stopped until software starts it again. The block is built around a three-state controller: OFF (stopped), RUN (counting) and FIRE (one cycle of reset request).

The controller's transitions are:
- OFF→RUN on start.
- RUN→RUN on restart, which reloads the count.
- RUN→OFF on stop.
- RUN→FIRE on expiry.
- FIRE→RUN on start.
- FIRE→OFF otherwise.

Top module: `wdt_top`

## Requirements
- R1: After reset, `sys_rst_req`, `pwr_off_req` and `wd_event` are 0, and every readable register reads 0x00.
- R2: The preset register is at address 2. A write stores all 8 bits, and a read returns them.
- R3: The control register is at address 0.
  - On read, bit 7 is the power-off option, bit 6 is the timebase (1 = long, 0 = short) and bit 4 is 1 while the watchdog is counting. All other bits read 0.
  - Every control write updates bits 7 and 6.
  - Writing 1 to bit 4 starts the watchdog.
- R4: In short timebase, with preset N ≥ 1, `sys_rst_req` is high for exactly one cycle. That cycle follows the edge that samples the Nth `tick_in` pulse after the start.
- R5: In long timebase, one unit is `LONG_DIV` (default 30) `tick_in` pulses, so preset N expires on pulse N·`LONG_DIV`.
- R6: Writing 1 to control bit 4 while counting reloads the count from the preset and clears the partial unit, which restarts the full timeout.
- R7: Writing 1 to control bit 5 stops the watchdog. Bit 4 then reads 0 and no reset request follows, whatever ticks arrive.
- R8: A single control write with both bit 5 and bit 4 set leaves the watchdog stopped.
- R9: Expiry sets a sticky flag, which is visible as `wd_event` and as bit 1 of the state register at address 1.
  - Writing 1 to state bit 1 clears the flag.
  - Writing 0 to state bit 1 leaves the flag set.
- R10: `pwr_off_req` pulses in the same cycle as `sys_rst_req` only when control bit 7 is set and `thermal` was high at expiry. Otherwise it stays 0.
- R11: A preset of 0 expires on the first unit tick, just like a preset of 1.
- R12: After expiry the watchdog is stopped. Control bit 4 reads 0, and further ticks cause no reset request until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 state, 2 preset) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational from `rd_addr`) |
| tick_in | input | 1 | One-cycle pulse per short time unit |
| thermal | input | 1 | Thermal event present |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry |
| pwr_off_req | output | 1 | One-cycle power-off request on thermal-qualified expiry |
| wd_event | output | 1 | Sticky watchdog-fired alarm |

## Verification
The bench targets these corner cases:
- **Off-by-one in the countdown.** A design that gets it wrong fires one tick early or one tick late, including the preset-0 case.
- **Prescaler not cleared on restart.** Such a design expires before a full long unit has elapsed.
- **Stop losing to start in a combined write.** Such a design keeps running.
- **Restarting after expiry without a new start.** Such a design produces repeated reset pulses.
- **Flag handling.** The bench checks that writing 0 to the state register leaves the fired flag set and that writing 1 clears it.
- **Power-off qualification.** Power-off is tried with the option bit alone, with the thermal input alone, and with both, so a design that qualifies on only one of them is caught.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_t;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PRESET = 2'd2;

    localparam int CB_PWROFF = 7;
    localparam int CB_LONG   = 6;
    localparam int CB_STOP   = 5;
    localparam int CB_START  = 4;
    localparam int SB_FIRED  = 1;

endpackage

// File: rtl/wdt_unit_tick.sv
module wdt_unit_tick #(
    parameter int LONG_DIV = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic tb_long,
    input  logic clear,
    output logic unit_tick
);
    generate
        if (LONG_DIV <= 1) begin : g_nodiv
            assign unit_tick = tick_in;
        end else begin : g_div
            localparam int PW = $clog2(LONG_DIV);
            localparam logic [PW-1:0] LAST = PW'(LONG_DIV - 1);
            logic [PW-1:0] pre_q;
            logic          wrap;

            assign wrap = (pre_q == LAST);

            always_ff @(posedge clk) begin
                if (!rst_n || clear || !tb_long) begin
                    pre_q <= '0;
                end else if (tick_in) begin
                    pre_q <= wrap ? '0 : pre_q + 1'b1;
                end
            end

            assign unit_tick = tick_in && (!tb_long || wrap);
        end
    endgenerate
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              expire,
    input  logic              running,
    output logic [CNT_W-1:0]  preset,
    output logic              pwroff_en,
    output logic              tb_long,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              fired
);
    logic ctrl_wr, state_wr, preset_wr;

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign state_wr  = wr_en && (wr_addr == A_STATE);
    assign preset_wr = wr_en && (wr_addr == A_PRESET);

    assign cmd_start = ctrl_wr && wr_data[CB_START];
    assign cmd_stop  = ctrl_wr && wr_data[CB_STOP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset    <= '0;
            pwroff_en <= 1'b0;
            tb_long   <= 1'b0;
        end else begin
            if (preset_wr) preset <= wr_data[CNT_W-1:0];
            if (ctrl_wr) begin
                pwroff_en <= wr_data[CB_PWROFF];
                tb_long   <= wr_data[CB_LONG];
            end
        end
    end

    // sticky flag: setting on expiry outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                             fired <= 1'b0;
        else if (expire)                        fired <= 1'b1;
        else if (state_wr && wr_data[SB_FIRED]) fired <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[CB_PWROFF] = pwroff_en;
                rd_data[CB_LONG]   = tb_long;
                rd_data[CB_START]  = running;
            end
            A_STATE:  rd_data[SB_FIRED] = fired;
            A_PRESET: rd_data[CNT_W-1:0] = preset;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [CNT_W-1:0] preset,
    input  logic             pwroff_en,
    input  logic             thermal,
    output logic             running,
    output logic             expire,
    output logic             load,
    output logic             sys_rst_req,
    output logic             pwr_off_req
);
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pwr_q;
    logic             last_unit;

    assign load      = cmd_start && !cmd_stop;
    assign last_unit = (cnt_q <= CNT_W'(1));

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (load) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (cmd_stop)                    state_d = WD_OFF;
                else if (cmd_start)              state_d = WD_RUN;
                else if (unit_tick && last_unit) begin
                    state_d = WD_FIRE;
                    expire  = 1'b1;
                end
            end
            WD_FIRE: begin
                state_d = load ? WD_RUN : WD_OFF;
            end
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pwr_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= preset;
            end else if (state_q == WD_RUN && unit_tick && !last_unit) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (expire) pwr_q <= pwroff_en && thermal;
        end
    end

    always_comb begin
        running     = (state_q == WD_RUN);
        sys_rst_req = (state_q == WD_FIRE);
        pwr_off_req = (state_q == WD_FIRE) && pwr_q;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LONG_DIV = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       tick_in,
    input  logic       thermal,
    output logic       sys_rst_req,
    output logic       pwr_off_req,
    output logic       wd_event
);
    logic [CNT_W-1:0] preset;
    logic pwroff_en, tb_long, cmd_start, cmd_stop, fired;
    logic running, expire, load, unit_tick;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .expire(expire), .running(running), .preset(preset),
        .pwroff_en(pwroff_en), .tb_long(tb_long), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .fired(fired)
    );

    wdt_unit_tick #(.LONG_DIV(LONG_DIV)) u_unit (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tb_long(tb_long),
        .clear(load), .unit_tick(unit_tick)
    );

    wdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .preset(preset),
        .pwroff_en(pwroff_en), .thermal(thermal), .running(running),
        .expire(expire), .load(load), .sys_rst_req(sys_rst_req),
        .pwr_off_req(pwr_off_req)
    );

    assign wd_event = fired;
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       running,
    input logic       sys_rst_req,
    input logic       pwr_off_req,
    input logic       wd_event
);
    logic ctrl_wr, start_only, stop_wr, clr_wr;

    assign ctrl_wr    = wr_en && (wr_addr == 2'd0);
    assign start_only = ctrl_wr && wr_data[4] && !wr_data[5];
    assign stop_wr    = ctrl_wr && wr_data[5];
    assign clr_wr     = wr_en && (wr_addr == 2'd1) && wr_data[1];

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    a_r4_fire_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(running));

    a_r10_pwr_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req |-> sys_rst_req);

    a_r9_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> wd_event);

    a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!wd_event || sys_rst_req));

    a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!running && !sys_rst_req));

    a_r12_off_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !start_only) |=> !running);
endmodule

bind wdt_top wdt_top_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .running(running), .sys_rst_req(sys_rst_req),
    .pwr_off_req(pwr_off_req), .wd_event(wd_event)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick_in = 1'b0;
    logic       thermal = 1'b0;
    logic       sys_rst_req, pwr_off_req, wd_event;

    int nchk = 0;
    int nfail = 0;
    int rst_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top #(.CNT_W(8), .LONG_DIV(DIV)) u_wdt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_in(tick_in), .thermal(thermal), .sys_rst_req(sys_rst_req),
        .pwr_off_req(pwr_off_req), .wd_event(wd_event)
    );

    always @(negedge clk) if (rst_n && sys_rst_req) rst_cnt++;

    typedef struct packed {
        logic [7:0] preset;
        logic       lng;
        logic       pwren;
        logic       therm;
        logic [7:0] ticks;
        logic       exp_pwr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd1, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0},
        '{8'd3, 1'b0, 1'b0, 1'b0, 8'd3,  1'b0},
        '{8'd0, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0},
        '{8'd5, 1'b0, 1'b1, 1'b1, 8'd5,  1'b1},
        '{8'd2, 1'b0, 1'b1, 1'b0, 8'd2,  1'b0},
        '{8'd2, 1'b0, 1'b0, 1'b1, 8'd2,  1'b0},
        '{8'd1, 1'b1, 1'b0, 1'b0, 8'd30, 1'b0},
        '{8'd2, 1'b1, 1'b1, 1'b1, 8'd60, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1;
            @(negedge clk); #1;
            tick_in = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 sys_rst_req", {7'd0, sys_rst_req}, 8'd0);
        check("R1 pwr_off_req", {7'd0, pwr_off_req}, 8'd0);
        check("R1 wd_event", {7'd0, wd_event}, 8'd0);
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 state", v, 8'h00);
        rd(2'd2, v); check("R1 preset", v, 8'h00);

        // R2 preset readback
        wr(2'd2, 8'hA5); rd(2'd2, v); check("R2 preset", v, 8'hA5);
        // R3 control readback: option, long, enabled
        wr(2'd0, 8'hD0); rd(2'd0, v); check("R3 ctrl", v, 8'hD0);
        wr(2'd0, 8'h20); rd(2'd0, v); check("R7 stopped", v, 8'h00);

        // vector table: R4 R5 R10 R11 R9 R12
        for (int k = 0; k < 8; k++) begin
            thermal = VECS[k].therm;
            wr(2'd2, VECS[k].preset);
            wr(2'd0, {VECS[k].pwren, VECS[k].lng, 2'b01, 4'b0000});
            base = rst_cnt;
            ticks(int'(VECS[k].ticks) - 1);
            check("R4 no early fire", 8'(rst_cnt - base), 8'd0);
            ticks(1);
            check("R4 rst pulse", {7'd0, sys_rst_req}, 8'd1);
            check("R10 pwr", {7'd0, pwr_off_req}, {7'd0, VECS[k].exp_pwr});
            @(negedge clk); #1;
            check("R4 one cycle", 8'(rst_cnt - base), 8'd1);
            check("R9 event", {7'd0, wd_event}, 8'd1);
            rd(2'd0, v); check("R12 stopped", v & 8'h10, 8'h00);
            rd(2'd1, v); check("R9 flag", v, 8'h02);
            wr(2'd1, 8'h02);
            thermal = 1'b0;
        end

        // R12 no repeat after expiry
        base = rst_cnt;
        ticks(10);
        check("R12 no repeat", 8'(rst_cnt - base), 8'd0);

        // R9 write 0 keeps flag, write 1 clears
        wr(2'd2, 8'd1); wr(2'd0, 8'h10); ticks(1); @(negedge clk); #1;
        wr(2'd1, 8'h00); rd(2'd1, v); check("R9 keep on 0", v, 8'h02);
        wr(2'd1, 8'h02); rd(2'd1, v); check("R9 clear", v, 8'h00);
        check("R9 event clear", {7'd0, wd_event}, 8'd0);

        // R6 restart in short timebase
        wr(2'd2, 8'd3); wr(2'd0, 8'h10);
        base = rst_cnt;
        ticks(2); wr(2'd0, 8'h10); ticks(2);
        check("R6 short restart", 8'(rst_cnt - base), 8'd0);
        ticks(1); #0;
        check("R6 short fire", {7'd0, sys_rst_req}, 8'd1);
        @(negedge clk); #1; wr(2'd1, 8'h02);

        // R6 restart clears partial long unit
        wr(2'd2, 8'd1); wr(2'd0, 8'h50);
        base = rst_cnt;
        ticks(20); wr(2'd0, 8'h50); ticks(DIV - 1);
        check("R6 long restart", 8'(rst_cnt - base), 8'd0);
        ticks(1);
        check("R6 long fire", {7'd0, sys_rst_req}, 8'd1);
        @(negedge clk); #1; wr(2'd1, 8'h02);

        // R7 stop while running
        wr(2'd2, 8'd2); wr(2'd0, 8'h10); ticks(1);
        wr(2'd0, 8'h20);
        rd(2'd0, v); check("R7 bit4 clear", v, 8'h00);
        base = rst_cnt; ticks(5);
        check("R7 no fire", 8'(rst_cnt - base), 8'd0);

        // R8 stop wins over start, from stopped and from running
        wr(2'd0, 8'h30); rd(2'd0, v); check("R8 from off", v, 8'h00);
        wr(2'd0, 8'h10); wr(2'd0, 8'h30); rd(2'd0, v); check("R8 from run", v, 8'h00);
        base = rst_cnt; ticks(5);
        check("R8 no fire", 8'(rst_cnt - base), 8'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule